// File: doc/BRIEF.md
# Predicated Vector Float-to-Unsigned Converter

This block converts a whole vector of floating-point elements to unsigned integers in one pass, truncating every value toward zero. A format select picks one of seven source/result pairings. Half, single or double precision sources can produce 16, 32 or 64-bit results. The vector is cut into lanes as wide as the larger of the two element sizes. The narrower value sits unpacked in the low bits of its lane.

A governing predicate, one bit per byte, chooses which lanes take a new result. Lanes that are not active pass the old destination value through, so the block merges into an existing register image. Each conversion also returns two sticky-style flags, invalid and inexact. Each flag is the OR over the active lanes.

The block accepts one operation per clock. All outputs are registered and valid one cycle after the request.

Top module: `fcvtu_vec`

## Requirements
- R1: `in_sel` encodes the pairing as 0=H→16, 1=H→32, 2=H→64, 3=S→32, 4=S→64, 5=D→32, 6=D→64. Lane width is 16 for code 0, 32 for codes 1 and 3, and 64 for codes 2, 4, 5 and 6.
- R2: A finite positive value below 2^d (d = result width) converts to its integer part. Inexact is set exactly when a nonzero fraction is discarded.
- R3: +Inf and any value at or above 2^d give all ones in the d result bits and raise invalid without inexact.
- R4: -0 gives 0 with no flag. A negative value of magnitude below 1 gives 0 and raises inexact only. A value of -1 or below, and -Inf, give 0 and raise invalid.
- R5: A NaN of any sign gives 0 and raises invalid.
- R6: +0 gives 0 with no flag. A nonzero subnormal gives 0 and raises inexact.
- R7: When the source is narrower than the lane, only its low bits are read, and the upper lane bits have no effect on the result or the flags.
- R8: When the result is narrower than the lane, the upper lane bits of an active lane are written with zeros.
- R9: A lane is active when the predicate bit at its lowest byte (bit index lane×lanewidth/8) is 1. An inactive lane keeps its `in_old` bits.
- R10: Flags come only from active lanes. With no active lane, the output equals `in_old` and both flags are 0.
- R11: The result appears on the clock edge after `in_valid`, with `out_valid` high for exactly that cycle. Select code 7 returns `in_old` with no flags.
- R12: Synchronous active-high reset clears `out_valid`, `out_data` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_sel | input | 3 | Source/result pairing code |
| in_src | input | VL | Source vector of floating-point elements |
| in_pred | input | VL/8 | Governing predicate, one bit per byte |
| in_old | input | VL | Previous destination contents |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_data | output | VL | Merged destination vector |
| out_invalid | output | 1 | Invalid flag over active lanes |
| out_inexact | output | 1 | Inexact flag over active lanes |

## Verification
The hardest case to reach is a set of operands that sit exactly on the saturation edge of one result width. Examples are the largest finite value just under 2^d, or 2^d itself. A random generator almost never lands on these, so they are driven as fixed encodings for every pairing. A second hard case is the predicate. Bits set at non-lowest byte positions of a lane, together with NaNs in inactive lanes, must leave both the data and the flags untouched. Dedicated predicate patterns reach this case. After that, random vectors with exponents drawn around the bias and the saturation point are compared against a reference model built on real arithmetic.

// File: rtl/fcvtu_pkg.sv
package fcvtu_pkg;

  typedef enum logic [2:0] {
    CV_H16  = 3'd0,
    CV_H32  = 3'd1,
    CV_H64  = 3'd2,
    CV_S32  = 3'd3,
    CV_S64  = 3'd4,
    CV_D32  = 3'd5,
    CV_D64  = 3'd6,
    CV_NONE = 3'd7
  } cvt_sel_e;

  typedef enum logic [1:0] {
    SRC_H = 2'd0,
    SRC_S = 2'd1,
    SRC_D = 2'd2
  } src_kind_e;

  typedef struct packed {
    logic [63:0] val;
    logic        inv;
    logic        inx;
  } cvt_res_t;

  function automatic int unsigned lane_bits(input cvt_sel_e s);
    case (s)
      CV_H16:         return 16;
      CV_H32, CV_S32: return 32;
      default:        return 64;
    endcase
  endfunction

  function automatic int unsigned dst_bits(input cvt_sel_e s);
    case (s)
      CV_H16:                 return 16;
      CV_H32, CV_S32, CV_D32: return 32;
      default:                return 64;
    endcase
  endfunction

  function automatic src_kind_e src_of(input cvt_sel_e s);
    case (s)
      CV_H16, CV_H32, CV_H64: return SRC_H;
      CV_S32, CV_S64:         return SRC_S;
      default:                return SRC_D;
    endcase
  endfunction

  // Truncating conversion of one element to a dw-bit unsigned integer.
  function automatic cvt_res_t fp_to_uint(input logic [63:0] raw,
                                          input src_kind_e k,
                                          input int unsigned dw);
    cvt_res_t    r;
    logic        sgn;
    logic [10:0] ef, emax;
    logic [51:0] fr;
    int          bias, e, sh;
    logic [63:0] m, ones;
    r    = '0;
    ones = (dw >= 64) ? '1 : ((64'd1 << dw) - 64'd1);
    case (k)
      SRC_H: begin
        sgn = raw[15]; ef = {6'd0, raw[14:10]}; fr = {raw[9:0], 42'd0};
        emax = 11'd31; bias = 15;
      end
      SRC_S: begin
        sgn = raw[31]; ef = {3'd0, raw[30:23]}; fr = {raw[22:0], 29'd0};
        emax = 11'd255; bias = 127;
      end
      default: begin
        sgn = raw[63]; ef = raw[62:52]; fr = raw[51:0];
        emax = 11'd2047; bias = 1023;
      end
    endcase
    if (ef == emax) begin
      r.inv = 1'b1;
      if (fr == '0 && !sgn) r.val = ones;
    end else if (ef == '0) begin
      r.inx = (fr != '0);
    end else begin
      e = int'(ef) - bias;
      if (e < 0) begin
        r.inx = 1'b1;
      end else if (sgn) begin
        r.inv = 1'b1;
      end else if (e >= int'(dw)) begin
        r.val = ones;
        r.inv = 1'b1;
      end else begin
        m = {11'd0, 1'b1, fr};
        if (e <= 52) begin
          sh    = 52 - e;
          r.val = m >> sh;
          r.inx = (m & ((64'd1 << sh) - 64'd1)) != '0;
        end else begin
          r.val = m << (e - 52);
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/fcvtu_lane.sv
module fcvtu_lane
  import fcvtu_pkg::*;
#(
  parameter int LW = 64
) (
  input  cvt_sel_e        sel,
  input  logic [LW-1:0]   din,
  output logic [LW-1:0]   dout,
  output logic            inv,
  output logic            inx
);

  cvt_res_t res;

  always_comb begin
    res  = fp_to_uint(64'(din), src_of(sel), dst_bits(sel));
    dout = LW'(res.val);
    inv  = res.inv;
    inx  = res.inx;
  end

  // The two flags never appear together on one element.
  always_comb begin
    if (!$isunknown({sel, din}))
      assert_flag_excl_R3: assert (!(inv && inx))
        else $error("lane raised invalid and inexact together");
  end

  // An invalid element reports either zero or the saturation pattern.
  always_comb begin
    if (!$isunknown({sel, din}) && inv)
      assert_inv_value_R5: assert (dout == '0 ||
        dout == ((dst_bits(sel) >= LW) ? {LW{1'b1}}
                                       : ((LW'(1) << dst_bits(sel)) - LW'(1))))
        else $error("invalid lane carries an unexpected value");
  end

endmodule

// File: rtl/fcvtu_bank.sv
module fcvtu_bank
  import fcvtu_pkg::*;
#(
  parameter int VL = 128,
  parameter int LW = 64
) (
  input  cvt_sel_e        sel,
  input  logic [VL-1:0]   src,
  input  logic [VL/8-1:0] pred,
  input  logic [VL-1:0]   old,
  output logic [VL-1:0]   merged,
  output logic            inv,
  output logic            inx
);

  localparam int NL  = VL / LW;
  localparam int BPL = LW / 8;

  logic [NL-1:0] act, l_inv, l_inx;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] conv;
    logic          ci, cx;

    assign act[i] = pred[i*BPL];

    fcvtu_lane #(.LW(LW)) u_lane (
      .sel  (sel),
      .din  (src[i*LW +: LW]),
      .dout (conv),
      .inv  (ci),
      .inx  (cx)
    );

    assign merged[i*LW +: LW] = act[i] ? conv : old[i*LW +: LW];
    assign l_inv[i] = act[i] & ci;
    assign l_inx[i] = act[i] & cx;
  end

  assign inv = |l_inv;
  assign inx = |l_inx;

endmodule

// File: rtl/fcvtu_vec.sv
module fcvtu_vec
  import fcvtu_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      in_sel,
  input  logic [VL-1:0]   in_src,
  input  logic [VL/8-1:0] in_pred,
  input  logic [VL-1:0]   in_old,
  output logic            out_valid,
  output logic [VL-1:0]   out_data,
  output logic            out_invalid,
  output logic            out_inexact
);

  localparam int NB = 3;   // lane widths 16, 32, 64

  cvt_sel_e      sel_e;
  logic [VL-1:0] bank_d [NB];
  logic [NB-1:0] bank_iv, bank_ix;
  logic [1:0]    pick;

  assign sel_e = cvt_sel_e'(in_sel);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    fcvtu_bank #(.VL(VL), .LW(16 << g)) u_bank (
      .sel    (sel_e),
      .src    (in_src),
      .pred   (in_pred),
      .old    (in_old),
      .merged (bank_d[g]),
      .inv    (bank_iv[g]),
      .inx    (bank_ix[g])
    );
  end

  always_comb begin
    case (lane_bits(sel_e))
      16:      pick = 2'd0;
      32:      pick = 2'd1;
      default: pick = 2'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (sel_e == CV_NONE) begin
          out_data    <= in_old;
          out_invalid <= 1'b0;
          out_inexact <= 1'b0;
        end else begin
          out_data    <= bank_d[pick];
          out_invalid <= bank_iv[pick];
          out_inexact <= bank_ix[pick];
        end
      end
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_unused_sel_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sel == 3'd7) |=>
      (out_data == $past(in_old) && !out_invalid && !out_inexact));

  assert_no_active_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred == '0) |=>
      (out_data == $past(in_old) && !out_invalid && !out_inexact));

  assert_reset_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

endmodule

// File: tb/fcvtu_vec_tb.sv
module fcvtu_vec_tb;

  localparam int VL = 128;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [2:0]    in_sel;
  logic [VL-1:0] in_src, in_old;
  logic [PW-1:0] in_pred;
  logic          out_valid, out_invalid, out_inexact;
  logic [VL-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [VL-1:0] q_d[$];
  logic          q_iv[$];
  logic          q_ix[$];
  string         q_tag[$];

  always #10 clk = ~clk;

  fcvtu_vec #(.VL(VL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_src(in_src), .in_pred(in_pred), .in_old(in_old),
    .out_valid(out_valid), .out_data(out_data),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // ---------------- reference model (real arithmetic) ----------------
  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic int kind_of(input int s);
    if (s <= 2) return 0;
    if (s <= 4) return 1;
    return 2;
  endfunction

  function automatic int dw_of(input int s);
    if (s == 0) return 16;
    if (s == 1 || s == 3 || s == 5) return 32;
    return 64;
  endfunction

  function automatic int lw_of(input int s);
    if (s == 0) return 16;
    if (s == 1 || s == 3) return 32;
    return 64;
  endfunction

  function automatic int eb_of(input int k); return (k == 0) ? 5 : (k == 1) ? 8 : 11; endfunction
  function automatic int mb_of(input int k); return (k == 0) ? 10 : (k == 1) ? 23 : 52; endfunction

  // returns {val[63:0], inv, inx}
  function automatic logic [65:0] ref_cvt(input logic [63:0] raw, input int k, input int dw);
    int eb = eb_of(k), mb = mb_of(k);
    int bias = (1 << (eb - 1)) - 1;
    int emax = (1 << eb) - 1;
    logic s = raw[eb + mb];
    int ef = int'((raw >> mb) & ((64'd1 << eb) - 1));
    logic [63:0] fr = raw & ((64'd1 << mb) - 1);
    logic [63:0] ones = (dw == 64) ? '1 : ((64'd1 << dw) - 1);
    real v, hi, lo, lf;
    if (ef == emax) return {((fr == 0 && !s) ? ones : 64'd0), 1'b1, 1'b0};
    if (ef == 0) v = real'(fr) * pow2(1 - bias - mb);
    else         v = (real'(fr) + pow2(mb)) * pow2(ef - bias - mb);
    if (v == 0.0) return {64'd0, 2'b00};
    if (s) return (v >= 1.0) ? {64'd0, 2'b10} : {64'd0, 2'b01};
    if (v >= pow2(dw)) return {ones, 2'b10};
    hi = $floor(v / 4294967296.0);
    lo = v - hi * 4294967296.0;
    lf = $floor(lo);
    return {(64'(longint'(hi)) << 32) | 64'(longint'(lf)), 1'b0, (lo != lf)};
  endfunction

  task automatic model(input int sel, input logic [VL-1:0] src, input logic [PW-1:0] pr,
                       input logic [VL-1:0] old, output logic [VL-1:0] d,
                       output logic iv, output logic ix);
    int lw = lw_of(sel), k = kind_of(sel), dw = dw_of(sel);
    logic [VL-1:0] one = 1;
    logic [VL-1:0] lmask = (one << lw) - one;
    logic [63:0] smask = (eb_of(k) + mb_of(k) + 1 == 64) ? '1 : ((64'd1 << (eb_of(k) + mb_of(k) + 1)) - 1);
    logic [65:0] r;
    d = old; iv = 1'b0; ix = 1'b0;
    if (sel == 7) return;
    for (int i = 0; i < VL / lw; i++) begin
      if (pr[i * lw / 8]) begin
        r  = ref_cvt(64'((src >> (i * lw)) & lmask) & smask, k, dw);
        d  = (d & ~(lmask << (i * lw))) | (VL'(r[65:2]) << (i * lw));
        iv = iv | r[1];
        ix = ix | r[0];
      end
    end
  endtask

  // ---------------- driver ----------------
  task automatic send(input int sel, input logic [VL-1:0] src, input logic [PW-1:0] pr,
                      input logic [VL-1:0] old, input string tag);
    logic [VL-1:0] d; logic iv, ix;
    model(sel, src, pr, old, d, iv, ix);
    @(negedge clk);
    q_d.push_back(d); q_iv.push_back(iv); q_ix.push_back(ix); q_tag.push_back(tag);
    in_valid = 1'b1; in_sel = 3'(sel); in_src = src; in_pred = pr; in_old = old;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_src = {4{$urandom}};
  endtask

  function automatic logic [VL-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Place element e in the low bits of every lane; upper lane bits random (R7).
  function automatic logic [VL-1:0] fill(input int sel, input logic [63:0] e);
    int lw = lw_of(sel), k = kind_of(sel);
    int sb = eb_of(k) + mb_of(k) + 1;
    logic [VL-1:0] v = rnd_vec();
    logic [VL-1:0] one = 1;
    logic [VL-1:0] sm = (one << sb) - one;
    for (int i = 0; i < VL / lw; i++)
      v = (v & ~(sm << (i * lw))) | ((VL'(e) & sm) << (i * lw));
    return v;
  endfunction

  task automatic dir1(input int sel, input logic [63:0] e, input string tag);
    send(sel, fill(sel, e), '1, rnd_vec(), tag);
  endtask

  function automatic logic [63:0] mk_elem(input int k, input int dw);
    int eb = eb_of(k), mb = mb_of(k);
    int bias = (1 << (eb - 1)) - 1, emax = (1 << eb) - 1;
    int mode = int'($urandom % 10);
    int ex;
    logic [63:0] fr = {$urandom, $urandom} & ((64'd1 << mb) - 1);
    logic s = ($urandom % 4) == 0;
    if ($urandom % 4 == 0) fr = ($urandom % 2) ? 64'd0 : ((64'd1 << mb) - 1);
    if (mode == 0)      ex = emax;
    else if (mode == 1) ex = 0;
    else begin
      ex = bias - 2 + int'($urandom % 32'(dw + 4));
      if (ex < 1) ex = 1;
      if (ex > emax - 1) ex = emax - 1;
    end
    return (64'(s) << (eb + mb)) | (64'(ex) << mb) | fr;
  endfunction

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (q_d.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected out_valid: got 1 expected 0");
      end else begin
        logic [VL-1:0] ed; logic ei, ex; string t;
        ed = q_d.pop_front(); ei = q_iv.pop_front(); ex = q_ix.pop_front(); t = q_tag.pop_front();
        if (out_data !== ed || out_invalid !== ei || out_inexact !== ex) begin
          fails++;
          $display("FAIL %s data %h inv %b inx %b expected data %h inv %b inx %b",
                   t, out_data, out_invalid, out_inexact, ed, ei, ex);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sel = '0; in_src = '0; in_pred = '0; in_old = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset state: got v=%b d=%h expected v=0 d=0", out_valid, out_data);
    end
    rst = 1'b0;

    // R1, R2: plain values in every pairing
    for (int s = 0; s < 7; s++) begin
      int k = kind_of(s);
      dir1(s, (k == 0) ? 64'h3C00 : (k == 1) ? 64'h3F800000 : 64'h3FF0000000000000, "R1 one");
      dir1(s, (k == 0) ? 64'h3E00 : (k == 1) ? 64'h40700000 : 64'h3FF8000000000000, "R2 fraction");
      dir1(s, (k == 0) ? 64'h7C00 : (k == 1) ? 64'h7F800000 : 64'h7FF0000000000000, "R3 +Inf");
      dir1(s, (k == 0) ? 64'hFC00 : (k == 1) ? 64'hFF800000 : 64'hFFF0000000000000, "R4 -Inf");
      dir1(s, (k == 0) ? 64'hC000 : (k == 1) ? 64'hC0000000 : 64'hC000000000000000, "R4 minus two");
      dir1(s, (k == 0) ? 64'hB800 : (k == 1) ? 64'hBF000000 : 64'hBFE0000000000000, "R4 minus half");
      dir1(s, (k == 0) ? 64'h8000 : (k == 1) ? 64'h80000000 : 64'h8000000000000000, "R4 minus zero");
      dir1(s, (k == 0) ? 64'h7E00 : (k == 1) ? 64'h7FC00000 : 64'h7FF8000000000000, "R5 NaN");
      dir1(s, (k == 0) ? 64'hFE01 : (k == 1) ? 64'hFFC00001 : 64'hFFF8000000000001, "R5 negative NaN");
      dir1(s, (k == 0) ? 64'h0001 : (k == 1) ? 64'h00000001 : 64'h0000000000000001, "R6 subnormal");
      dir1(s, 64'h0, "R6 zero");
    end
    // R3: saturation boundaries
    dir1(0, 64'h7BFF, "R3 half max to 16");
    dir1(3, 64'h4F7FFFFF, "R3 just below 2^32");
    dir1(3, 64'h4F800000, "R3 at 2^32");
    dir1(4, 64'h4F800000, "R3 2^32 into 64");
    dir1(5, 64'h41EFFFFFFFE00000, "R3 double 2^32-1");
    dir1(5, 64'h41F0000000000000, "R3 double 2^32 into 32");
    dir1(6, 64'h43EFFFFFFFFFFFFF, "R3 just below 2^64");
    dir1(6, 64'h43F0000000000000, "R3 at 2^64");
    // R8: narrow result, zero-extended in wide lanes
    dir1(5, 64'h41DFFFFFFFC00000, "R8 D to 32 upper zeros");
    dir1(2, 64'h7BFF, "R8 H to 64 upper zeros");
    // R7: same element, different upper garbage
    dir1(1, 64'h4248, "R7 garbage upper half");
    dir1(4, 64'h40490FDB, "R7 garbage upper single");
    // R9: predicate bits away from lane lowest byte only
    send(6, fill(6, 64'h4000000000000000), 16'hFEFE, rnd_vec(), "R9 non-lowest bits only");
    send(3, fill(3, 64'h40000000), 16'hEEEE, rnd_vec(), "R9 non-lowest bits only");
    send(0, fill(0, 64'h4000), 16'h5555, rnd_vec(), "R9 alternate lanes");
    // R10: NaN in inactive lanes, no flags
    send(6, {64'h7FF8000000000000, 64'h4008000000000000}, 16'h00FF, rnd_vec(), "R10 inactive NaN");
    send(1, fill(1, 64'h7E00), 16'h0000, rnd_vec(), "R10 nothing active");
    // R11: unused select code and back-to-back stream
    send(7, fill(6, 64'h7FF8000000000000), '1, rnd_vec(), "R11 select 7");
    idle();
    repeat (2) @(negedge clk);
    // R9 R10 R2 random sweep
    for (int n = 0; n < 2500; n++) begin
      int s = int'($urandom % 8);
      int lw = (s == 7) ? 64 : lw_of(s);
      logic [VL-1:0] v = rnd_vec();
      int sb = eb_of(kind_of(s == 7 ? 6 : s)) + mb_of(kind_of(s == 7 ? 6 : s)) + 1;
      logic [VL-1:0] one = 1;
      logic [VL-1:0] sm = (one << sb) - one;
      for (int i = 0; i < VL / lw; i++)
        v = (v & ~(sm << (i * lw))) |
            ((VL'(mk_elem(kind_of(s == 7 ? 6 : s), dw_of(s == 7 ? 6 : s))) & sm) << (i * lw));
      send(s, v, PW'($urandom), rnd_vec(), "R9 R10 random");
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    // R11: every request produced exactly one result
    checks++;
    if (q_d.size() != 0) begin
      fails++;
      $display("FAIL R11 pending results: got %0d expected 0", q_d.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule